// File: doc/BRIEF.md
# Multiplexer-Based Programmable Logic Cell

This block is one fine-grained logic cell of a programmable array, replicated across a parameterised number of lanes. Each lane forms two select terms from small gate functions of its select-input pairs, steers one of four data inputs through a four-way multiplexer, and then passes the result through a storage stage whose kind is fixed by a static two-bit mode word. The stage can be bypassed (pure combinational cell), an edge-triggered register with asynchronous clear, a transparent latch without clear, or a transparent latch with clear. In the last case the multiplexer shrinks to a two-way choice so that the cell fits a clear input.

All lanes share the clock/gate input, the clear and the mode word, while their data and select inputs are independent. A chip-level active-low reset is asserted asynchronously and released through a short synchroniser on the cell clock. It empties the register and the latch.

Top module: `mxcell_top`

## Requirements
- R1: Per lane, the low select is the AND of `a0` and `b0`, and the high select is the OR of `a1` and `b1`.
- R2: With `mode` = 2'b00 the output is combinational. Select code {high,low} = 00, 01, 10, 11 gives `d00`, `d01`, `d10`, `d11` respectively. `clr` and `clk` have no effect on `y` in this mode.
- R3: With `mode` = 2'b01 the multiplexer result is stored on the rising edge of `clk`, and `y` holds that stored value between edges whatever the inputs do.
- R4: With `mode` = 2'b01 a high `clr` forces `y` to 0 at once, without waiting for a clock edge, and keeps it at 0 across edges while `clr` stays high.
- R5: With `mode` = 2'b10 `y` follows the multiplexer result while `clk` is high and holds the last value while `clk` is low.
- R6: With `mode` = 2'b10 `clr` has no effect on `y`.
- R7: With `mode` = 2'b11 the multiplexer is reduced to `d01` when the low select is 1 and to `d00` otherwise. `a1`, `b1`, `d10` and `d11` are ignored. The result then passes through the transparent latch of R5.
- R8: With `mode` = 2'b11 a high `clr` forces `y` to 0 at once, including while `clk` is high. Once `clr` drops, the latch is transparent again while `clk` is high.
- R9: A low `rst_n` forces `y` to 0 at once in modes 01, 10 and 11. After `rst_n` rises, the register first stores data on the third rising edge of `clk`.
- R10: Lanes are independent: each bit of `y` depends only on the same bit of the data and select inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock in mode 01; latch gate (transparent high) in modes 10 and 11 |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert, synchronised release |
| mode | input | 2 | Static configuration: 00 combinational, 01 register, 10 latch, 11 latch with clear |
| clr | input | 1 | Asynchronous clear, active high |
| a0 | input | LANES | First input of the AND select term |
| b0 | input | LANES | Second input of the AND select term |
| a1 | input | LANES | First input of the OR select term |
| b1 | input | LANES | Second input of the OR select term |
| d00 | input | LANES | Data chosen for select code 00 |
| d01 | input | LANES | Data chosen for select code 01 |
| d10 | input | LANES | Data chosen for select code 10 |
| d11 | input | LANES | Data chosen for select code 11 |
| y | output | LANES | Cell output per lane |

## Verification
The bench builds the cell with `LANES` = 4 and `RST_STAGES` = 2. Four lanes let a single vector put every lane on a different select code, so one sample checks all four multiplexer paths and lane independence together. The two-stage release makes the third-edge first capture after reset an exact, checkable cycle. Phase-aligned stimulus within the high and low halves of `clk` separates latch transparency from latch hold and shows that clears act without a clock edge.

// File: rtl/mxcell_pkg.sv
`timescale 1ns/1ps
package mxcell_pkg;

  typedef enum logic [1:0] {
    MODE_COMB      = 2'b00,
    MODE_FLOP      = 2'b01,
    MODE_LATCH     = 2'b10,
    MODE_LATCH_CLR = 2'b11
  } cell_mode_e;

  function automatic logic stage_has_clear(input cell_mode_e m);
    return (m == MODE_FLOP) || (m == MODE_LATCH_CLR);
  endfunction

endpackage

// File: rtl/mxcell_rst_sync.sv
`timescale 1ns/1ps
module mxcell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_s_n = chain_q[LAST];

endmodule

// File: rtl/mxcell_select.sv
`timescale 1ns/1ps
module mxcell_select #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] a0,
  input  logic [LANES-1:0] b0,
  input  logic [LANES-1:0] a1,
  input  logic [LANES-1:0] b1,
  output logic [LANES-1:0] sel_lo,
  output logic [LANES-1:0] sel_hi
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      sel_lo[i] = a0[i] & b0[i];
      sel_hi[i] = a1[i] | b1[i];
    end
  end

endmodule

// File: rtl/mxcell_mux.sv
`timescale 1ns/1ps
module mxcell_mux
  import mxcell_pkg::*;
#(
  parameter int LANES = 4
) (
  input  cell_mode_e       mode,
  input  logic [LANES-1:0] sel_lo,
  input  logic [LANES-1:0] sel_hi,
  input  logic [LANES-1:0] d00,
  input  logic [LANES-1:0] d01,
  input  logic [LANES-1:0] d10,
  input  logic [LANES-1:0] d11,
  output logic [LANES-1:0] mux_o
);

  logic reduced;
  assign reduced = (mode == MODE_LATCH_CLR);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic hi_eff;
    always_comb begin
      hi_eff = sel_hi[i] & ~reduced;
      unique case ({hi_eff, sel_lo[i]})
        2'b00:   mux_o[i] = d00[i];
        2'b01:   mux_o[i] = d01[i];
        2'b10:   mux_o[i] = d10[i];
        default: mux_o[i] = d11[i];
      endcase
    end
  end

endmodule

// File: rtl/mxcell_store.sv
`timescale 1ns/1ps
module mxcell_store
  import mxcell_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_s_n,
  input  logic             clr,
  input  cell_mode_e       mode,
  input  logic [LANES-1:0] din,
  output logic [LANES-1:0] y
);

  logic             flop_en;
  logic             lat_clr;
  logic [LANES-1:0] ff_d;
  logic [LANES-1:0] ff_q;
  logic [LANES-1:0] lat_q;

  assign flop_en = (mode == MODE_FLOP);
  assign lat_clr = clr & stage_has_clear(mode) & (mode != MODE_FLOP);

  always_comb begin
    ff_d = flop_en ? din : ff_q;
  end

  always_ff @(posedge clk or negedge rst_s_n or posedge clr) begin
    if (!rst_s_n)  ff_q <= '0;
    else if (clr)  ff_q <= '0;
    else           ff_q <= ff_d;
  end

  always_latch begin
    if (!rst_s_n || lat_clr) lat_q <= '0;
    else if (clk)            lat_q <= din;
  end

  always_comb begin
    unique case (mode)
      MODE_COMB: y = din;
      MODE_FLOP: y = ff_q;
      default:   y = lat_q;
    endcase
  end

endmodule

// File: rtl/mxcell_top.sv
`timescale 1ns/1ps
module mxcell_top
  import mxcell_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             clr,
  input  logic [LANES-1:0] a0,
  input  logic [LANES-1:0] b0,
  input  logic [LANES-1:0] a1,
  input  logic [LANES-1:0] b1,
  input  logic [LANES-1:0] d00,
  input  logic [LANES-1:0] d01,
  input  logic [LANES-1:0] d10,
  input  logic [LANES-1:0] d11,
  output logic [LANES-1:0] y
);

  cell_mode_e       mode_e;
  logic             rst_s_n;
  logic [LANES-1:0] sel_lo;
  logic [LANES-1:0] sel_hi;
  logic [LANES-1:0] mux_o;

  assign mode_e = cell_mode_e'(mode);

  mxcell_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  mxcell_select #(.LANES(LANES)) u_sel (
    .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .sel_lo(sel_lo), .sel_hi(sel_hi)
  );

  mxcell_mux #(.LANES(LANES)) u_mux (
    .mode(mode_e), .sel_lo(sel_lo), .sel_hi(sel_hi),
    .d00(d00), .d01(d01), .d10(d10), .d11(d11), .mux_o(mux_o)
  );

  mxcell_store #(.LANES(LANES)) u_store (
    .clk(clk), .rst_s_n(rst_s_n), .clr(clr), .mode(mode_e),
    .din(mux_o), .y(y)
  );

  // Port-level reference for the combinational function
  logic [LANES-1:0] ref_lo;
  logic [LANES-1:0] ref_hi;
  logic [LANES-1:0] ref_comb;
  assign ref_lo   = a0 & b0;
  assign ref_hi   = a1 | b1;
  assign ref_comb = (~ref_hi & ~ref_lo & d00) | (~ref_hi & ref_lo & d01) |
                    ( ref_hi & ~ref_lo & d10) | ( ref_hi & ref_lo & d11);

  AST_COMB_FUNC: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_COMB) |-> (y == ref_comb)) else $error("comb function"); // R2

  AST_FLOP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_FLOP && !clr && rst_s_n) |=>
      (mode != MODE_FLOP || clr || y == $past(mux_o))) else $error("flop capture"); // R3

  AST_FLOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_FLOP && clr) |-> (y == '0)) else $error("flop clear"); // R4

  AST_LATCH_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode == MODE_LATCH_CLR && clr) |-> (y == '0)) else $error("latch clear"); // R8

endmodule

// File: tb/mxcell_top_test.sv
`timescale 1ns/1ps
module mxcell_top_test;

  localparam int  LANES = 4;
  localparam time HALF  = 2ns;
  localparam int  NVEC  = 9;

  // fields: a0 b0 a1 b1 d00 d01 d10 d11 expected
  localparam logic [35:0] VEC [NVEC] = '{
    {4'b1011, 4'b1110, 4'b0100, 4'b1000, 4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1111},
    {4'b1011, 4'b1110, 4'b0100, 4'b1000, 4'b1110, 4'b1101, 4'b1011, 4'b0111, 4'b0000},
    {4'b1011, 4'b1110, 4'b0100, 4'b1000, 4'b1111, 4'b0000, 4'b0000, 4'b0000, 4'b0001},
    {4'b0000, 4'b0000, 4'b0000, 4'b0000, 4'b0101, 4'b1010, 4'b1010, 4'b1010, 4'b0101},
    {4'b1111, 4'b1111, 4'b0000, 4'b0000, 4'b1001, 4'b0110, 4'b1001, 4'b1001, 4'b0110},
    {4'b1111, 4'b0000, 4'b1111, 4'b0000, 4'b1100, 4'b1100, 4'b0011, 4'b1100, 4'b0011},
    {4'b0000, 4'b1111, 4'b0000, 4'b1111, 4'b0110, 4'b0110, 4'b1001, 4'b0110, 4'b1001},
    {4'b1111, 4'b1111, 4'b0000, 4'b1111, 4'b0011, 4'b0011, 4'b0011, 4'b1100, 4'b1100},
    {4'b1111, 4'b0101, 4'b0000, 4'b0000, 4'b0000, 4'b1111, 4'b1010, 4'b1010, 4'b0101}
  };

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode;
  logic             clr;
  logic [LANES-1:0] a0, b0, a1, b1, d00, d01, d10, d11;
  logic [LANES-1:0] y;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  done     = 1'b0;

  always #(HALF) clk = ~clk;

  mxcell_top #(.LANES(LANES), .RST_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .clr(clr),
    .a0(a0), .b0(b0), .a1(a1), .b1(b1),
    .d00(d00), .d01(d01), .d10(d10), .d11(d11), .y(y)
  );

  task automatic check(input string tag, input logic [LANES-1:0] exp);
    n_checks++;
    if (y !== exp) begin
      n_errors++;
      $display("FAIL %s: y=%b expected %b at %0t", tag, y, exp, $time);
    end
  endtask

  task automatic apply(input logic [35:0] v);
    {a0, b0, a1, b1, d00, d01, d10, d11} = v[35:4];
  endtask

  initial begin
    #(200000 * 4ns);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mode  = 2'b01;
    clr   = 1'b0;
    apply(VEC[0]);
    #(3ns);
    check("R9 reset holds register at zero", 4'b0000);

    // synchronised release: first capture on third rising edge
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1ns; check("R9 no capture on edge 1", 4'b0000);
    @(posedge clk); #1ns; check("R9 no capture on edge 2", 4'b0000);
    @(posedge clk); #1ns; check("R9 capture on edge 3", 4'b1111);

    // register hold and capture
    @(negedge clk); #1ns; apply(VEC[1]); #0.5ns;
    check("R3 hold between edges", 4'b1111);
    @(posedge clk); #1ns; check("R3 capture new data", 4'b0000);
    @(negedge clk); #1ns; apply(VEC[0]);
    @(posedge clk); #1ns; check("R3 capture again", 4'b1111);

    // asynchronous clear of the register
    @(negedge clk); #0.5ns; clr = 1'b1; #0.5ns;
    check("R4 clear without clock edge", 4'b0000);
    @(posedge clk); #1ns; check("R4 clear held across edge", 4'b0000);
    @(negedge clk); #0.5ns; clr = 1'b0; #0.5ns;
    check("R4 stays cleared until edge", 4'b0000);
    @(posedge clk); #1ns; check("R3 capture after clear", 4'b1111);

    // combinational table walk
    @(negedge clk); mode = 2'b00;
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk); #0.5ns;
      apply(VEC[i]);
      clr = (i % 2 == 1);
      #1ns;
      if (i == 0)      check("R10 each lane own select code", VEC[i][3:0]);
      else if (i < 3)  check("R2 combinational mux", VEC[i][3:0]);
      else             check("R1 select gate terms", VEC[i][3:0]);
    end
    @(posedge clk); #1ns; check("R2 clock and clr do not disturb", VEC[NVEC-1][3:0]);
    clr = 1'b0;

    // plain latch
    @(negedge clk); #0.5ns; mode = 2'b10; apply(VEC[0]);
    @(posedge clk); #0.5ns; check("R5 transparent while high", 4'b1111);
    apply(VEC[1]); #0.5ns; check("R5 follows change while high", 4'b0000);
    @(negedge clk); #0.5ns; apply(VEC[0]); #0.5ns;
    check("R5 holds while low", 4'b0000);
    clr = 1'b1; #0.5ns;
    check("R6 clr ignored while low", 4'b0000);
    @(posedge clk); #0.5ns; check("R6 clr ignored while high", 4'b1111);
    @(negedge clk); #0.5ns; clr = 1'b0;

    // latch with clear, reduced mux
    mode = 2'b11;
    a0 = 4'b1011; b0 = 4'b1110; a1 = 4'b0000; b1 = 4'b0000;
    d00 = 4'b0101; d01 = 4'b1010; d10 = 4'b0000; d11 = 4'b0000;
    @(posedge clk); #0.5ns; check("R7 reduced two-way mux", 4'b1111);
    a1 = 4'b1111; b1 = 4'b1111; #0.5ns;
    check("R7 high select ignored", 4'b1111);
    clr = 1'b1; #0.3ns;
    check("R8 clear while gate high", 4'b0000);
    @(posedge clk); #0.5ns; check("R8 clear held", 4'b0000);
    clr = 1'b0; #0.5ns;
    check("R8 transparent after clear drops", 4'b1111);

    // reset with latch selected
    @(negedge clk); #0.5ns; rst_n = 1'b0; #0.5ns;
    check("R9 reset clears latch", 4'b0000);
    @(posedge clk); #0.5ns; check("R9 latch held by reset", 4'b0000);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule